// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider Controller

This block is the digital counting section of an integer-N frequency synthesizer. A reference divider counts reference pulses and emits one pulse every R of them. A second divider takes pulses from a dual-modulus prescaler. Its swallow counter holds the prescaler at P+1 for the first A prescaler periods of each count cycle. Its main counter then finishes the cycle at P. One VCO-side output pulse is therefore produced every P*B+A VCO cycles. Both divided pulse trains go to a phase/frequency detector.

Configuration arrives over a three-wire serial port: a clock, a data line and a latch line. A word carries a target code and a payload that loads R, the A/B pair, or the control fields. The control fields are the prescaler modulus selection, a 2-bit charge-pump current code and the charge-pump polarity. The serial lines are sampled and synchronized in the system clock domain. The reference input and the prescaler input are one-cycle event pulses in that same domain.

A loaded divider value takes effect only when the running count cycle completes. Because of this, the phase detector never sees a truncated or stretched cycle.

Top module: `pll_divctl`

## Requirements
- R1: After reset the control outputs are all zero. This means `psc_sel`=0 (modulus 16), `cp_current`=0, `cp_polarity`=0 and `cfg_error`=0. R=1, A=0 and B=1, so the VCO-side period is 16 VCO cycles and `mod_sel` is low.
- R2: A serial word is 24 bits, shifted MSB first on each rising `ser_clk`. Shifting alone changes nothing. The word is applied on the rising edge of `ser_latch`. Bits [23:22] pick the target: 00 = reference divider, 01 = swallow/main pair, 10 = control, 11 = none.
- R3: With A and B loaded and modulus P selected, `vco_div_out` pulses once every P*B+A VCO cycles. P is 16 when `psc_sel`=0 and 32 when it is 1. The pair word carries B in bits [12:0] and A in bits [18:13].
- R4: In each VCO-side count cycle, `mod_sel` (1 = divide by P+1) is high for exactly the first A prescaler periods. That is A*(P+1) VCO cycles. With A=0 it stays low for the whole cycle.
- R5: `ref_div_out` pulses once every R reference pulses. The reference word carries R in bits [13:0].
- R6: A control word sets `psc_sel` from bit 0, `cp_current` from bits [2:1] and `cp_polarity` from bit 3. Polarity 0 means sourcing current while the VCO runs slow.
- R7: A pair word with B=0 or B<A, and a reference word with R=0, is rejected. The divider settings stay unchanged and `cfg_error` is set. A later accepted pair or reference word clears `cfg_error`.
- R8: A word with target 11 changes no output and no divider ratio.
- R9: New A, B and R values load only at the end of the running count cycle. The first complete cycle after that boundary uses the new ratio.
- R10: Each divided output pulse lasts one clock. It appears one clock after the input pulse that completes the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous, sampled) |
| ser_data | input | 1 | Serial data, MSB first |
| ser_latch | input | 1 | Rising edge applies the shifted word |
| ref_pulse | input | 1 | One-cycle pulse per reference period |
| pre_pulse | input | 1 | One-cycle pulse per prescaler output period |
| ref_div_out | output | 1 | Divided reference pulse |
| vco_div_out | output | 1 | Divided VCO pulse |
| mod_sel | output | 1 | Prescaler modulus control, 1 = P+1 |
| psc_sel | output | 1 | Modulus selection, 0 = 16, 1 = 32 |
| cp_current | output | 2 | Charge-pump current code |
| cp_polarity | output | 1 | Charge-pump sign |
| cfg_error | output | 1 | Last pair/reference word was rejected |

## Verification
The divider is swept over both moduli, A from 0 to 3 and B in {1, 3, 7}, with A never above B. This covers A=0 (no swallowing), A=B (every period at P+1) and B=1 (the shortest cycle). The measured output period separates P*B+A from P*B or from A and B swapped. Counting the VCO cycles spent with `mod_sel` high tells a correct swallow count from one that is off by a prescaler period. Illegal pair and reference words, a target-11 word and a shift without a latch are each followed by a period measurement, which shows the ratio did not move. A ratio change is also checked on the first full cycle after its boundary.

// File: rtl/pll_divctl_pkg.sv
package pll_divctl_pkg;

    localparam int WORD_W = 24;
    localparam int SEL_W  = 2;
    localparam int R_W    = 14;
    localparam int A_W    = 6;
    localparam int B_W    = 13;
    localparam int CP_W   = 2;

    typedef enum logic [SEL_W-1:0] {
        TGT_REF  = 2'b00,
        TGT_SWAL = 2'b01,
        TGT_CTRL = 2'b10,
        TGT_NONE = 2'b11
    } tgt_e;

    typedef struct packed {
        logic [A_W-1:0] a_val;
        logic [B_W-1:0] b_val;
    } nprog_t;

    typedef struct packed {
        logic            psc_32;
        logic [CP_W-1:0] cp_cur;
        logic            cp_pol;
    } ctrl_t;

    function automatic tgt_e word_target(input logic [WORD_W-1:0] w);
        return tgt_e'(w[WORD_W-1 -: SEL_W]);
    endfunction

    function automatic nprog_t word_nprog(input logic [WORD_W-1:0] w);
        nprog_t n;
        n.b_val = w[B_W-1:0];
        n.a_val = w[B_W +: A_W];
        return n;
    endfunction

    function automatic ctrl_t word_ctrl(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.psc_32 = w[0];
        c.cp_cur = w[CP_W:1];
        c.cp_pol = w[CP_W+1];
        return c;
    endfunction

    function automatic logic nprog_ok(input nprog_t n);
        return (n.b_val != '0) && (n.b_val >= B_W'(n.a_val));
    endfunction

endpackage

// File: rtl/pll_serial_if.sv
module pll_serial_if
    import pll_divctl_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_latch,
    output logic [R_W-1:0] r_prog,
    output nprog_t         n_prog,
    output ctrl_t          ctrl,
    output logic           cfg_error
);

    logic [SYNC_LEN:0]   sclk_q;
    logic [SYNC_LEN:0]   slat_q;
    logic [SYNC_LEN-1:0] sdat_q;
    logic [WORD_W-1:0]   shreg;
    logic                shift_en;
    logic                latch_en;
    nprog_t              n_new;
    logic [R_W-1:0]      r_new;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= '0;
            slat_q <= '0;
            sdat_q <= '0;
        end else begin
            sclk_q <= {sclk_q[SYNC_LEN-1:0], ser_clk};
            slat_q <= {slat_q[SYNC_LEN-1:0], ser_latch};
            sdat_q <= {sdat_q[SYNC_LEN-2:0], ser_data};
        end
    end

    assign shift_en = sclk_q[SYNC_LEN-1] & ~sclk_q[SYNC_LEN];
    assign latch_en = slat_q[SYNC_LEN-1] & ~slat_q[SYNC_LEN];
    assign n_new    = word_nprog(shreg);
    assign r_new    = shreg[R_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (shift_en) begin
            shreg <= {shreg[WORD_W-2:0], sdat_q[SYNC_LEN-1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_prog       <= R_W'(1);
            n_prog.a_val <= '0;
            n_prog.b_val <= B_W'(1);
            ctrl         <= '0;
            cfg_error    <= 1'b0;
        end else if (latch_en) begin
            unique case (word_target(shreg))
                TGT_REF: begin
                    if (r_new != '0) begin
                        r_prog    <= r_new;
                        cfg_error <= 1'b0;
                    end else begin
                        cfg_error <= 1'b1;
                    end
                end
                TGT_SWAL: begin
                    if (nprog_ok(n_new)) begin
                        n_prog    <= n_new;
                        cfg_error <= 1'b0;
                    end else begin
                        cfg_error <= 1'b1;
                    end
                end
                TGT_CTRL: ctrl <= word_ctrl(shreg);
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div
    import pll_divctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_pulse,
    input  logic [R_W-1:0] r_prog,
    output logic           ref_div_out,
    output logic [R_W-1:0] r_act,
    output logic [R_W-1:0] r_cnt
);

    logic r_last;

    assign r_last = (r_cnt == r_act - R_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            r_cnt       <= '0;
            r_act       <= R_W'(1);
            ref_div_out <= 1'b0;
        end else begin
            ref_div_out <= 1'b0;
            if (ref_pulse) begin
                if (r_last) begin
                    r_cnt       <= '0;
                    r_act       <= r_prog;
                    ref_div_out <= 1'b1;
                end else begin
                    r_cnt <= r_cnt + R_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/pll_swallow_div.sv
module pll_swallow_div
    import pll_divctl_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           pre_pulse,
    input  nprog_t         n_prog,
    output logic           mod_sel,
    output logic           vco_div_out,
    output logic [A_W-1:0] a_act,
    output logic [B_W-1:0] b_act,
    output logic [B_W-1:0] b_cnt
);

    logic [A_W-1:0] a_cnt;
    logic           b_last;
    logic           a_open;

    assign a_open  = (a_cnt < a_act);
    assign b_last  = (b_cnt == b_act - B_W'(1));
    assign mod_sel = a_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_cnt       <= '0;
            b_cnt       <= '0;
            a_act       <= '0;
            b_act       <= B_W'(1);
            vco_div_out <= 1'b0;
        end else begin
            vco_div_out <= 1'b0;
            if (pre_pulse) begin
                if (b_last) begin
                    a_cnt       <= '0;
                    b_cnt       <= '0;
                    a_act       <= n_prog.a_val;
                    b_act       <= n_prog.b_val;
                    vco_div_out <= 1'b1;
                end else begin
                    b_cnt <= b_cnt + B_W'(1);
                    if (a_open) begin
                        a_cnt <= a_cnt + A_W'(1);
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pll_divctl.sv
module pll_divctl
    import pll_divctl_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_clk,
    input  logic       ser_data,
    input  logic       ser_latch,
    input  logic       ref_pulse,
    input  logic       pre_pulse,
    output logic       ref_div_out,
    output logic       vco_div_out,
    output logic       mod_sel,
    output logic       psc_sel,
    output logic [1:0] cp_current,
    output logic       cp_polarity,
    output logic       cfg_error
);

    logic [R_W-1:0] r_prog;
    nprog_t         n_prog;
    ctrl_t          ctrl;
    logic [R_W-1:0] r_act;
    logic [R_W-1:0] r_cnt;
    logic [A_W-1:0] a_act;
    logic [B_W-1:0] b_act;
    logic [B_W-1:0] b_cnt;

    pll_serial_if #(.SYNC_LEN(SYNC_LEN)) u_ser (
        .clk       (clk),
        .rst       (rst),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .r_prog    (r_prog),
        .n_prog    (n_prog),
        .ctrl      (ctrl),
        .cfg_error (cfg_error)
    );

    pll_ref_div u_ref (
        .clk         (clk),
        .rst         (rst),
        .ref_pulse   (ref_pulse),
        .r_prog      (r_prog),
        .ref_div_out (ref_div_out),
        .r_act       (r_act),
        .r_cnt       (r_cnt)
    );

    pll_swallow_div u_swal (
        .clk         (clk),
        .rst         (rst),
        .pre_pulse   (pre_pulse),
        .n_prog      (n_prog),
        .mod_sel     (mod_sel),
        .vco_div_out (vco_div_out),
        .a_act       (a_act),
        .b_act       (b_act),
        .b_cnt       (b_cnt)
    );

    assign psc_sel     = ctrl.psc_32;
    assign cp_current  = ctrl.cp_cur;
    assign cp_polarity = ctrl.cp_pol;

endmodule

// File: rtl/pll_divctl_checker.sv
module pll_divctl_checker
    import pll_divctl_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           ref_pulse,
    input logic           pre_pulse,
    input logic           ref_div_out,
    input logic           vco_div_out,
    input logic           mod_sel,
    input logic [R_W-1:0] r_act,
    input logic [R_W-1:0] r_cnt,
    input logic [A_W-1:0] a_act,
    input logic [B_W-1:0] b_act,
    input logic [B_W-1:0] b_cnt
);

    assert_vco_after_pre_R10: assert property (@(posedge clk) disable iff (rst)
        vco_div_out |-> $past(pre_pulse));

    assert_ref_after_ref_R10: assert property (@(posedge clk) disable iff (rst)
        ref_div_out |-> $past(ref_pulse));

    assert_mod_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (a_act == '0) |-> !mod_sel);

    assert_pair_legal_R7: assert property (@(posedge clk) disable iff (rst)
        (b_act != '0) && (b_act >= B_W'(a_act)));

    assert_ref_legal_R7: assert property (@(posedge clk) disable iff (rst)
        r_act != '0);

    assert_pair_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(a_act) || !$stable(b_act)) |-> vco_div_out);

    assert_ref_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(r_act) |-> ref_div_out);

    assert_main_range_R3: assert property (@(posedge clk) disable iff (rst)
        b_cnt < b_act);

    assert_ref_range_R5: assert property (@(posedge clk) disable iff (rst)
        r_cnt < r_act);

endmodule

bind pll_divctl pll_divctl_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_pulse   (ref_pulse),
    .pre_pulse   (pre_pulse),
    .ref_div_out (ref_div_out),
    .vco_div_out (vco_div_out),
    .mod_sel     (mod_sel),
    .r_act       (r_act),
    .r_cnt       (r_cnt),
    .a_act       (a_act),
    .b_act       (b_act),
    .b_cnt       (b_cnt)
);

// File: tb/pll_divctl_bench.sv
module pll_divctl_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_latch = 1'b0;
    logic       ref_pulse = 1'b0;
    logic       pre_pulse = 1'b0;
    logic       ref_div_out;
    logic       vco_div_out;
    logic       mod_sel;
    logic       psc_sel;
    logic [1:0] cp_current;
    logic       cp_polarity;
    logic       cfg_error;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int psc_cnt = 0;
    int psc_mod = 16;
    int ref_div = 0;
    int vco_cyc = 0, vco_hi = 0, vco_per = 0, vco_hi_per = 0, vco_ev = 0;
    int ref_cyc = 0, ref_per = 0, ref_ev = 0;

    pll_divctl u_pll_divctl (
        .clk         (clk),
        .rst         (rst),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .ser_latch   (ser_latch),
        .ref_pulse   (ref_pulse),
        .pre_pulse   (pre_pulse),
        .ref_div_out (ref_div_out),
        .vco_div_out (vco_div_out),
        .mod_sel     (mod_sel),
        .psc_sel     (psc_sel),
        .cp_current  (cp_current),
        .cp_polarity (cp_polarity),
        .cfg_error   (cfg_error)
    );

    always #2 clk = ~clk;

    // behavioural prescaler: one VCO cycle per clock, modulus sampled at period start
    always @(negedge clk) begin
        if (rst) begin
            psc_cnt   = 0;
            pre_pulse = 1'b0;
            ref_pulse = 1'b0;
            ref_div   = 0;
        end else begin
            if (psc_cnt == 0)
                psc_mod = (psc_sel ? 32 : 16) + (mod_sel ? 1 : 0);
            psc_cnt++;
            if (psc_cnt == psc_mod) begin
                pre_pulse = 1'b1;
                psc_cnt   = 0;
            end else begin
                pre_pulse = 1'b0;
            end
            ref_div++;
            if (ref_div == 3) begin
                ref_pulse = 1'b1;
                ref_div   = 0;
            end else begin
                ref_pulse = 1'b0;
            end
        end
    end

    // period monitors
    always @(negedge clk) begin
        if (!rst) begin
            vco_cyc++;
            if (mod_sel) vco_hi++;
            if (vco_div_out) begin
                vco_per    = vco_cyc;
                vco_hi_per = vco_hi;
                vco_cyc    = 0;
                vco_hi     = 0;
                vco_ev++;
            end
            ref_cyc++;
            if (ref_div_out) begin
                ref_per = ref_cyc;
                ref_cyc = 0;
                ref_ev++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [23:0] w);
        for (int i = 23; i >= 0; i--) begin
            ser_data = w[i];
            repeat (3) @(negedge clk);
            ser_clk = 1'b1;
            repeat (3) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic latch_word();
        ser_latch = 1'b1;
        repeat (3) @(negedge clk);
        ser_latch = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_word(input logic [23:0] w);
        shift_word(w);
        latch_word();
    endtask

    function automatic logic [23:0] mk_ref(input int r);
        return {2'b00, 8'b0, 14'(r)};
    endfunction

    function automatic logic [23:0] mk_pair(input int a, input int b);
        return {2'b01, 3'b0, 6'(a), 13'(b)};
    endfunction

    function automatic logic [23:0] mk_ctrl(input bit p32, input int cp, input bit pol);
        return {2'b10, 18'b0, pol, 2'(cp), p32};
    endfunction

    task automatic wait_vco(input int n);
        int s;
        s = vco_ev;
        wait (vco_ev >= s + n);
        @(negedge clk);
    endtask

    task automatic wait_ref(input int n);
        int s;
        s = ref_ev;
        wait (ref_ev >= s + n);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int pv;
        int bl [3] = '{1, 3, 7};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(psc_sel == 1'b0, "R1 psc_sel", psc_sel, 0);
        chk(cp_current == 2'd0, "R1 cp_current", cp_current, 0);
        chk(cp_polarity == 1'b0, "R1 cp_polarity", cp_polarity, 0);
        chk(cfg_error == 1'b0, "R1 cfg_error", cfg_error, 0);
        chk(mod_sel == 1'b0, "R1 mod_sel", mod_sel, 0);
        wait_vco(2);
        chk(vco_per == 16, "R1 default vco period", vco_per, 16);
        wait_ref(2);
        chk(ref_per == 3, "R1 default ref period", ref_per, 3);

        // R3/R4 sweep over both moduli and A/B corners
        for (int p = 0; p < 2; p++) begin
            pv = p ? 32 : 16;
            send_word(mk_ctrl(p[0], 0, 1'b0));
            for (int bi = 0; bi < 3; bi++) begin
                for (int a = 0; a < 4; a++) begin
                    if (a <= bl[bi]) begin
                        send_word(mk_pair(a, bl[bi]));
                        wait_vco(3);
                        chk(vco_per == pv * bl[bi] + a, "R3 R2 ratio P*B+A", vco_per, pv * bl[bi] + a);
                        chk(vco_hi_per == a * (pv + 1), "R4 cycles at P+1", vco_hi_per, a * (pv + 1));
                    end
                end
            end
        end

        // R9 first full cycle after boundary uses the new ratio
        send_word(mk_ctrl(1'b0, 0, 1'b0));
        send_word(mk_pair(1, 6));
        wait_vco(3);
        send_word(mk_pair(3, 4));
        wait_vco(1);
        wait_vco(1);
        chk(vco_per == 67, "R9 first cycle after change", vco_per, 67);

        // R5 reference divider
        for (int ri = 0; ri < 4; ri++) begin
            int rv;
            rv = (ri == 0) ? 1 : (ri == 1) ? 2 : (ri == 2) ? 5 : 9;
            send_word(mk_ref(rv));
            wait_ref(3);
            chk(ref_per == 3 * rv, "R5 ref period", ref_per, 3 * rv);
        end
        send_word(mk_ref(4));
        wait_ref(1);
        wait_ref(1);
        chk(ref_per == 12, "R9 ref first cycle after change", ref_per, 12);

        // R6 control fields
        send_word(mk_ctrl(1'b1, 2, 1'b1));
        chk(psc_sel == 1'b1, "R6 psc_sel", psc_sel, 1);
        chk(cp_current == 2'd2, "R6 cp_current", cp_current, 2);
        chk(cp_polarity == 1'b1, "R6 cp_polarity", cp_polarity, 1);
        send_word(mk_ctrl(1'b0, 1, 1'b0));
        chk(psc_sel == 1'b0, "R6 psc_sel back", psc_sel, 0);
        chk(cp_current == 2'd1, "R6 cp_current 1", cp_current, 1);
        chk(cp_polarity == 1'b0, "R6 cp_polarity 0", cp_polarity, 0);

        // R7 rejected words
        send_word(mk_pair(2, 4));
        wait_vco(3);
        chk(vco_per == 66, "R7 baseline", vco_per, 66);
        send_word(mk_pair(5, 3));
        chk(cfg_error == 1'b1, "R7 error on B<A", cfg_error, 1);
        wait_vco(3);
        chk(vco_per == 66, "R7 ratio kept after B<A", vco_per, 66);
        send_word(mk_pair(0, 0));
        chk(cfg_error == 1'b1, "R7 error on B=0", cfg_error, 1);
        wait_vco(3);
        chk(vco_per == 66, "R7 ratio kept after B=0", vco_per, 66);
        send_word(mk_ref(0));
        chk(cfg_error == 1'b1, "R7 error on R=0", cfg_error, 1);
        wait_ref(3);
        chk(ref_per == 12, "R7 ref kept after R=0", ref_per, 12);
        send_word(mk_pair(1, 2));
        chk(cfg_error == 1'b0, "R7 error cleared", cfg_error, 0);
        wait_vco(3);
        chk(vco_per == 33, "R7 valid word applied", vco_per, 33);

        // R8 target 11 ignored
        send_word({2'b11, 22'h3FFFFF});
        chk(psc_sel == 1'b0, "R8 psc_sel", psc_sel, 0);
        chk(cp_current == 2'd1, "R8 cp_current", cp_current, 1);
        chk(cp_polarity == 1'b0, "R8 cp_polarity", cp_polarity, 0);
        chk(cfg_error == 1'b0, "R8 cfg_error", cfg_error, 0);
        wait_vco(3);
        chk(vco_per == 33, "R8 ratio", vco_per, 33);
        wait_ref(2);
        chk(ref_per == 12, "R8 ref ratio", ref_per, 12);

        // R2 shifting without latch has no effect
        shift_word(mk_ctrl(1'b1, 3, 1'b1));
        repeat (10) @(negedge clk);
        chk(psc_sel == 1'b0, "R2 no latch psc_sel", psc_sel, 0);
        chk(cp_current == 2'd1, "R2 no latch cp_current", cp_current, 1);
        latch_word();
        chk(psc_sel == 1'b1, "R2 latched psc_sel", psc_sel, 1);
        chk(cp_current == 2'd3, "R2 latched cp_current", cp_current, 3);
        wait_vco(3);
        chk(vco_per == 65, "R2 R3 ratio at P=32", vco_per, 65);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule